// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns a 16-bit compressed RISC-V integer instruction into the 32-bit base-ISA word that does the same work. A decode stage that already speaks the base encoding can then handle both lengths. Two control inputs change how the same 16-bit pattern is read. The first picks a 32-bit or a 64-bit register width. The second is the compressed-extension enable bit taken from the machine ISA register. Alongside the 32-bit word, the block raises an illegal flag for any pattern it must not execute: reserved forms, forms that only exist at the other register width, floating-point compressed forms, non-compressed patterns, and everything while the extension is disabled.

The block holds no state and has no clock. A word offered on the input side appears on the output side in the same cycle. The handshake is a plain valid/ready pass-through. Output valid mirrors input valid and input ready mirrors output ready, so a transfer happens on both sides in the same cycle. Back-pressure from downstream reaches upstream without delay. The producer must hold its word stable while valid is high and ready is low, and the expanded word then stays stable as well. The expanded word and the illegal flag depend only on the instruction and the two control inputs, never on the handshake.

Top module: `cexp_expander`

## Requirements
- R1: `out_valid` always equals `in_valid` and `in_ready` always equals `out_ready`, in the same cycle with no storage.
- R2: When `misa_c` is 0, `out_illegal` is 1 for every input word.
- R3: Whenever `out_illegal` is 1, `out_insn` is 32'h0. A word whose two low bits are 2'b11 is not compressed and is illegal.
- R4: The all-zero word is illegal, and so is the stack-pointer add-and-scale form (quadrant 0, funct3 000) when its scaled immediate is zero.
- R5: A 3-bit register field in bits [4:2] or [9:7] names register x8 plus the field value in the expanded word.
- R6: With bit 12 = 0, quadrant 2, funct3 100: a nonzero rs2 field (bits [6:2]) expands to `add rd, x0, rs2`. A zero rs2 field expands to `jalr x0, 0(rs1)`, which is illegal when rs1 (bits [11:7]) is zero.
- R7: With bit 12 = 1, quadrant 2, funct3 100: rs1 and rs2 both zero expands to ebreak (32'h00100073). rs2 zero alone expands to `jalr x1, 0(rs1)`. Otherwise the word expands to `add rd, rd, rs2`.
- R8: Quadrant 1, funct3 001 expands to `jal x1, offset` at width 32. At width 64 it expands to `addiw rd, rd, imm`, which is illegal when rd is zero.
- R9: Quadrant 1, funct3 110 expands to `beq rs1', x0` and funct3 111 to `bne rs1', x0`, with the sign-extended scaled offset.
- R10: At width 32 the doubleword loads and stores (register- and stack-relative) and the 32-bit add and subtract forms (quadrant 1, funct3 100, bits [12:10] = 3'b111, bits [6:5] = 00 or 01) are illegal. At width 64 they expand to ld, sd, subw and addw.
- R11: A shift (left, logical right, arithmetic right) with a zero 6-bit shift amount is illegal. At width 32 a shift amount above 31 (bit 12 set) is illegal.
- R12: Stack-relative word and doubleword loads with rd = 0 are illegal. The stack-pointer adjust and upper-immediate forms with a zero immediate are illegal. The floating-point compressed slots and the quadrant 0 funct3 100 slot are illegal.
- R13: Every legal compressed word, with `xlen64` 0 (width 32) or 1 (width 64), expands to the standard base-ISA equivalent: same operation, registers and immediate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_valid | input | 1 | Upstream offers a compressed word |
| in_ready | output | 1 | Block can accept the word (mirrors out_ready) |
| in_insn | input | 16 | Compressed instruction word |
| xlen64 | input | 1 | 1 selects 64-bit register width, 0 selects 32-bit |
| misa_c | input | 1 | Compressed-extension enable from the machine ISA register |
| out_valid | output | 1 | Expanded word is offered downstream (mirrors in_valid) |
| out_ready | input | 1 | Downstream accepts the expanded word |
| out_insn | output | 32 | Expanded base-ISA instruction, zero when illegal |
| out_illegal | output | 1 | Input cannot be executed as a compressed instruction |

## Verification
The assertions check several properties continuously. They cover the handshake mirror, the disabled-extension and non-compressed cases, and the zero output on illegal. They also check that a legal expansion always ends in 2'b11, that width 32 never yields a word-sized opcode, and that no width-32 shift carries a sixth shift-amount bit. Whether each expansion is the right instruction with the right registers and immediate can only be shown by the bench. It sweeps all 65536 words at both widths, with the extension both on and off, against its own arithmetic expansion. Hand-built words then pin down the shared encodings and the reserved corners.

// File: rtl/cexp_pkg.sv
package cexp_pkg;

  localparam int CW = 16;
  localparam int XW = 32;
  localparam int RW = 5;

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_IMM32  = 7'b0011011;
  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_REG32  = 7'b0111011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  localparam logic [XW-1:0] WORD_EBREAK = 32'h0010_0073;

  localparam logic [RW-1:0] REG_ZERO = 5'd0;
  localparam logic [RW-1:0] REG_LINK = 5'd1;
  localparam logic [RW-1:0] REG_SP   = 5'd2;

  typedef struct packed {
    logic          ill;
    logic [XW-1:0] word;
  } cexp_res_t;

  localparam cexp_res_t RES_ILL = '{ill: 1'b1, word: '0};

  function automatic cexp_res_t res_ok(input logic [XW-1:0] w);
    res_ok = '{ill: 1'b0, word: w};
  endfunction

  // 3-bit compact register field to full index (x8..x15)
  function automatic logic [RW-1:0] creg(input logic [2:0] f);
    creg = {2'b01, f};
  endfunction

  function automatic logic [XW-1:0] enc_i(input logic [11:0] imm, input logic [RW-1:0] rs1,
                                          input logic [2:0] f3, input logic [RW-1:0] rd,
                                          input logic [6:0] op);
    enc_i = {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [XW-1:0] enc_s(input logic [11:0] imm, input logic [RW-1:0] rs2,
                                          input logic [RW-1:0] rs1, input logic [2:0] f3);
    enc_s = {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE};
  endfunction

  function automatic logic [XW-1:0] enc_r(input logic [6:0] f7, input logic [RW-1:0] rs2,
                                          input logic [RW-1:0] rs1, input logic [2:0] f3,
                                          input logic [RW-1:0] rd, input logic [6:0] op);
    enc_r = {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic logic [XW-1:0] enc_b(input logic [12:0] imm, input logic [RW-1:0] rs1,
                                          input logic [2:0] f3);
    enc_b = {imm[12], imm[10:5], REG_ZERO, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
  endfunction

  function automatic logic [XW-1:0] enc_j(input logic [20:0] imm, input logic [RW-1:0] rd);
    enc_j = {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
  endfunction

  function automatic logic [XW-1:0] enc_u(input logic [19:0] imm, input logic [RW-1:0] rd);
    enc_u = {imm, rd, OPC_LUI};
  endfunction

endpackage

// File: rtl/cexp_quad0.sv
// Quadrant 0: stack-pointer add-and-scale, register-relative loads and stores
module cexp_quad0
  import cexp_pkg::*;
(
  input  logic [CW-1:2] insn,
  input  logic          xlen64,
  output cexp_res_t     res
);

  logic [2:0]    f3;
  logic [RW-1:0] rdp;
  logic [RW-1:0] rs1p;
  logic [9:0]    spn_imm;
  logic [6:0]    w_off;
  logic [7:0]    d_off;

  assign f3      = insn[15:13];
  assign rdp     = creg(insn[4:2]);
  assign rs1p    = creg(insn[9:7]);
  assign spn_imm = {insn[10:7], insn[12:11], insn[5], insn[6], 2'b00};
  assign w_off   = {insn[5], insn[12:10], insn[6], 2'b00};
  assign d_off   = {insn[6:5], insn[12:10], 3'b000};

  always_comb begin
    res = RES_ILL;
    unique case (f3)
      3'b000: if (spn_imm != '0)
                res = res_ok(enc_i({2'b00, spn_imm}, REG_SP, 3'b000, rdp, OPC_IMM));
      3'b010: res = res_ok(enc_i({5'b0, w_off}, rs1p, 3'b010, rdp, OPC_LOAD));
      3'b011: if (xlen64)
                res = res_ok(enc_i({4'b0, d_off}, rs1p, 3'b011, rdp, OPC_LOAD));
      3'b110: res = res_ok(enc_s({5'b0, w_off}, rdp, rs1p, 3'b010));
      3'b111: if (xlen64)
                res = res_ok(enc_s({4'b0, d_off}, rdp, rs1p, 3'b011));
      default: res = RES_ILL;
    endcase
  end

endmodule

// File: rtl/cexp_quad1.sv
// Quadrant 1: immediate ALU, upper immediate, compact ALU, jumps, branches
module cexp_quad1
  import cexp_pkg::*;
(
  input  logic [CW-1:2] insn,
  input  logic          xlen64,
  output cexp_res_t     res
);

  logic [2:0]    f3;
  logic [RW-1:0] rd;
  logic [RW-1:0] rs1p;
  logic [RW-1:0] rs2p;
  logic [5:0]    imm6;
  logic [11:0]   imm12;
  logic [11:0]   jofs;
  logic [8:0]    bofs;
  logic [9:0]    sp16;
  logic [5:0]    shamt;
  logic          shift_bad;

  assign f3     = insn[15:13];
  assign rd     = insn[11:7];
  assign rs1p   = creg(insn[9:7]);
  assign rs2p   = creg(insn[4:2]);
  assign imm6   = {insn[12], insn[6:2]};
  assign imm12  = {{6{insn[12]}}, imm6};
  assign jofs   = {insn[12], insn[8], insn[10:9], insn[6], insn[7], insn[2], insn[11],
                   insn[5:3], 1'b0};
  assign bofs   = {insn[12], insn[6:5], insn[2], insn[11:10], insn[4:3], 1'b0};
  assign sp16   = {insn[12], insn[4:3], insn[5], insn[2], insn[6], 4'b0000};
  assign shamt  = imm6;
  assign shift_bad = (shamt == '0) || (!xlen64 && shamt[5]);

  always_comb begin
    res = RES_ILL;
    unique case (f3)
      3'b000: res = res_ok(enc_i(imm12, rd, 3'b000, rd, OPC_IMM));
      3'b001: begin
        if (xlen64) begin
          if (rd != REG_ZERO)
            res = res_ok(enc_i(imm12, rd, 3'b000, rd, OPC_IMM32));
        end else begin
          res = res_ok(enc_j({{9{jofs[11]}}, jofs}, REG_LINK));
        end
      end
      3'b010: res = res_ok(enc_i(imm12, REG_ZERO, 3'b000, rd, OPC_IMM));
      3'b011: begin
        if (rd == REG_SP) begin
          if (sp16 != '0)
            res = res_ok(enc_i({{2{sp16[9]}}, sp16}, REG_SP, 3'b000, REG_SP, OPC_IMM));
        end else if (imm6 != '0) begin
          res = res_ok(enc_u({{14{insn[12]}}, imm6}, rd));
        end
      end
      3'b100: begin
        unique case (insn[11:10])
          2'b00, 2'b01: if (!shift_bad)
            res = res_ok(enc_i({1'b0, insn[10], 4'b0000, shamt}, rs1p, 3'b101, rs1p, OPC_IMM));
          2'b10: res = res_ok(enc_i(imm12, rs1p, 3'b111, rs1p, OPC_IMM));
          default: begin
            if (!insn[12]) begin
              unique case (insn[6:5])
                2'b00: res = res_ok(enc_r(7'b0100000, rs2p, rs1p, 3'b000, rs1p, OPC_REG));
                2'b01: res = res_ok(enc_r(7'b0000000, rs2p, rs1p, 3'b100, rs1p, OPC_REG));
                2'b10: res = res_ok(enc_r(7'b0000000, rs2p, rs1p, 3'b110, rs1p, OPC_REG));
                default: res = res_ok(enc_r(7'b0000000, rs2p, rs1p, 3'b111, rs1p, OPC_REG));
              endcase
            end else if (xlen64 && !insn[6]) begin
              res = res_ok(enc_r(insn[5] ? 7'b0000000 : 7'b0100000, rs2p, rs1p, 3'b000,
                                 rs1p, OPC_REG32));
            end
          end
        endcase
      end
      3'b101: res = res_ok(enc_j({{9{jofs[11]}}, jofs}, REG_ZERO));
      default: res = res_ok(enc_b({{4{bofs[8]}}, bofs}, rs1p, {2'b00, f3[0]}));
    endcase
  end

endmodule

// File: rtl/cexp_quad2.sv
// Quadrant 2: left shift, stack-relative loads/stores, move/add/jump-register group
module cexp_quad2
  import cexp_pkg::*;
(
  input  logic [CW-1:2] insn,
  input  logic          xlen64,
  output cexp_res_t     res
);

  logic [2:0]    f3;
  logic [RW-1:0] rd;
  logic [RW-1:0] rs2;
  logic [5:0]    shamt;
  logic [7:0]    lw_off;
  logic [8:0]    ld_off;
  logic [7:0]    sw_off;
  logic [8:0]    sd_off;

  assign f3     = insn[15:13];
  assign rd     = insn[11:7];
  assign rs2    = insn[6:2];
  assign shamt  = {insn[12], insn[6:2]};
  assign lw_off = {insn[3:2], insn[12], insn[6:4], 2'b00};
  assign ld_off = {insn[4:2], insn[12], insn[6:5], 3'b000};
  assign sw_off = {insn[8:7], insn[12:9], 2'b00};
  assign sd_off = {insn[9:7], insn[12:10], 3'b000};

  always_comb begin
    res = RES_ILL;
    unique case (f3)
      3'b000: if (shamt != '0 && (xlen64 || !shamt[5]))
                res = res_ok(enc_i({6'b0, shamt}, rd, 3'b001, rd, OPC_IMM));
      3'b010: if (rd != REG_ZERO)
                res = res_ok(enc_i({4'b0, lw_off}, REG_SP, 3'b010, rd, OPC_LOAD));
      3'b011: if (xlen64 && rd != REG_ZERO)
                res = res_ok(enc_i({3'b0, ld_off}, REG_SP, 3'b011, rd, OPC_LOAD));
      3'b100: begin
        if (!insn[12]) begin
          if (rs2 != REG_ZERO)
            res = res_ok(enc_r(7'b0, rs2, REG_ZERO, 3'b000, rd, OPC_REG));
          else if (rd != REG_ZERO)
            res = res_ok(enc_i(12'h000, rd, 3'b000, REG_ZERO, OPC_JALR));
        end else begin
          if (rs2 != REG_ZERO)
            res = res_ok(enc_r(7'b0, rs2, rd, 3'b000, rd, OPC_REG));
          else if (rd != REG_ZERO)
            res = res_ok(enc_i(12'h000, rd, 3'b000, REG_LINK, OPC_JALR));
          else
            res = res_ok(WORD_EBREAK);
        end
      end
      3'b110: res = res_ok(enc_s({4'b0, sw_off}, rs2, REG_SP, 3'b010));
      3'b111: if (xlen64)
                res = res_ok(enc_s({3'b0, sd_off}, rs2, REG_SP, 3'b011));
      default: res = RES_ILL;
    endcase
  end

endmodule

// File: rtl/cexp_expander.sv
module cexp_expander
  import cexp_pkg::*;
(
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_insn,
  input  logic          xlen64,
  input  logic          misa_c,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [XW-1:0] out_insn,
  output logic          out_illegal
);

  localparam int NQ = 3;

  cexp_res_t q_res [NQ];
  cexp_res_t sel;

  cexp_quad0 u_q0 (.insn(in_insn[CW-1:2]), .xlen64(xlen64), .res(q_res[0]));
  cexp_quad1 u_q1 (.insn(in_insn[CW-1:2]), .xlen64(xlen64), .res(q_res[1]));
  cexp_quad2 u_q2 (.insn(in_insn[CW-1:2]), .xlen64(xlen64), .res(q_res[2]));

  always_comb begin
    unique case (in_insn[1:0])
      2'b00:   sel = q_res[0];
      2'b01:   sel = q_res[1];
      2'b10:   sel = q_res[2];
      default: sel = RES_ILL;
    endcase
  end

  assign out_illegal = !misa_c || sel.ill;
  assign out_insn    = out_illegal ? '0 : sel.word;

  // stateless stream stage: handshake passes straight through
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

endmodule

// File: rtl/cexp_checker.sv
module cexp_checker
  import cexp_pkg::*;
(
  input logic          in_valid,
  input logic          in_ready,
  input logic [CW-1:0] in_insn,
  input logic          xlen64,
  input logic          misa_c,
  input logic          out_valid,
  input logic          out_ready,
  input logic [XW-1:0] out_insn,
  input logic          out_illegal
);

  always_comb begin
    a_r1_handshake: assert ((in_valid && in_ready) == (out_valid && out_ready)
                            && out_valid == in_valid);
    a_r2_disabled_ext: assert (misa_c || out_illegal);
    a_r3_zero_on_illegal: assert (!out_illegal || out_insn == '0);
    a_r3_not_compressed: assert (in_insn[1:0] != 2'b11 || out_illegal);
    a_r4_zero_word: assert (in_insn != '0 || out_illegal);
    a_r13_full_length: assert (out_illegal || out_insn[1:0] == 2'b11);
    a_r10_no_word_ops: assert (xlen64 || out_illegal
                               || (out_insn[6:0] != OPC_REG32 && out_insn[6:0] != OPC_IMM32));
    a_r11_narrow_shamt: assert (xlen64 || out_illegal || out_insn[6:0] != OPC_IMM
                                || out_insn[13:12] != 2'b01 || !out_insn[25]);
  end

endmodule

bind cexp_expander cexp_checker u_chk (.*);

// File: tb/cexp_expander_bench.sv
`timescale 1ns/1ps
module cexp_expander_bench;

  logic        clk = 1'b0;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [15:0] in_insn;
  logic        xlen64, misa_c;
  logic [31:0] out_insn;
  logic        out_illegal;
  int          checks = 0;
  int          failures = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cexp_expander u_cexp_expander (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] fi(int imm, int rs1, int f3, int rd, int op);
    logic [31:0] t = imm;
    logic [31:0] a = rs1, b = f3, c = rd, d = op;
    return {t[11:0], a[4:0], b[2:0], c[4:0], d[6:0]};
  endfunction
  function automatic logic [31:0] fs(int imm, int rs2, int rs1, int f3);
    logic [31:0] t = imm;
    logic [31:0] a = rs2, b = rs1, c = f3;
    return {t[11:5], a[4:0], b[4:0], c[2:0], t[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] fr(int f7, int rs2, int rs1, int f3, int rd, int op);
    logic [31:0] g = f7, a = rs2, b = rs1, c = f3, d = rd, e = op;
    return {g[6:0], a[4:0], b[4:0], c[2:0], d[4:0], e[6:0]};
  endfunction
  function automatic logic [31:0] fb(int imm, int rs1, int f3);
    logic [31:0] t = imm;
    logic [31:0] a = rs1, c = f3;
    return {t[12], t[10:5], 5'd0, a[4:0], c[2:0], t[4:1], t[11], 7'h63};
  endfunction
  function automatic logic [31:0] fj(int imm, int rd);
    logic [31:0] t = imm;
    logic [31:0] a = rd;
    return {t[20], t[10:1], t[11], t[19:12], a[4:0], 7'h6f};
  endfunction

  // independent arithmetic reference: {illegal, word}
  function automatic logic [32:0] ref_exp(logic [15:0] c, logic x64, logic mc);
    int rd = int'(c[11:7]);
    int r2 = int'(c[6:2]);
    int rdp = 8 + int'(c[4:2]);
    int r1p = 8 + int'(c[9:7]);
    int s6 = c[12] ? int'(c[6:2]) - 32 : int'(c[6:2]);
    int sh = int'(c[12]) * 32 + int'(c[6:2]);
    int jo = -2048 * int'(c[12]) + 1024 * int'(c[8]) + 256 * int'(c[10:9]) + 128 * int'(c[6])
             + 64 * int'(c[7]) + 32 * int'(c[2]) + 16 * int'(c[11]) + 2 * int'(c[5:3]);
    int bo = -256 * int'(c[12]) + 64 * int'(c[6:5]) + 32 * int'(c[2]) + 8 * int'(c[11:10])
             + 2 * int'(c[4:3]);
    int lwo = 8 * int'(c[12:10]) + 4 * int'(c[6]) + 64 * int'(c[5]);
    int ldo = 8 * int'(c[12:10]) + 64 * int'(c[6:5]);
    int u;
    logic [32:0] ILL = {1'b1, 32'h0};
    if (!mc || c[1:0] == 2'b11) return ILL;
    case (int'(c[1:0]) * 8 + int'(c[15:13]))
      0: begin
        u = 64 * int'(c[10:7]) + 16 * int'(c[12:11]) + 8 * int'(c[5]) + 4 * int'(c[6]);
        return (u == 0) ? ILL : {1'b0, fi(u, 2, 0, rdp, 'h13)};
      end
      2: return {1'b0, fi(lwo, r1p, 2, rdp, 3)};
      3: return x64 ? {1'b0, fi(ldo, r1p, 3, rdp, 3)} : ILL;
      6: return {1'b0, fs(lwo, rdp, r1p, 2)};
      7: return x64 ? {1'b0, fs(ldo, rdp, r1p, 3)} : ILL;
      8: return {1'b0, fi(s6, rd, 0, rd, 'h13)};
      9: if (x64) return (rd == 0) ? ILL : {1'b0, fi(s6, rd, 0, rd, 'h1b)};
         else return {1'b0, fj(jo, 1)};
      10: return {1'b0, fi(s6, 0, 0, rd, 'h13)};
      11: if (rd == 2) begin
            u = -512 * int'(c[12]) + 128 * int'(c[4:3]) + 64 * int'(c[5]) + 32 * int'(c[2])
                + 16 * int'(c[6]);
            return (u == 0) ? ILL : {1'b0, fi(u, 2, 0, 2, 'h13)};
          end else begin
            logic [31:0] t = s6;
            logic [31:0] dd = rd;
            return (s6 == 0) ? ILL : {1'b0, t[19:0], dd[4:0], 7'h37};
          end
      12: case (int'(c[11:10]))
            0, 1: if (sh == 0 || (!x64 && sh >= 32)) return ILL;
                  else return {1'b0, fi(1024 * int'(c[10]) + sh, r1p, 5, r1p, 'h13)};
            2: return {1'b0, fi(s6, r1p, 7, r1p, 'h13)};
            default: begin
              int o = int'(c[6:5]);
              int f3t [4] = '{0, 4, 6, 7};
              if (!c[12]) return {1'b0, fr(o == 0 ? 32 : 0, rdp, r1p, f3t[o], r1p, 'h33)};
              if (x64 && o < 2) return {1'b0, fr(o == 0 ? 32 : 0, rdp, r1p, 0, r1p, 'h3b)};
              return ILL;
            end
          endcase
      13: return {1'b0, fj(jo, 0)};
      14: return {1'b0, fb(bo, r1p, 0)};
      15: return {1'b0, fb(bo, r1p, 1)};
      16: if (sh == 0 || (!x64 && sh >= 32)) return ILL;
          else return {1'b0, fi(sh, rd, 1, rd, 'h13)};
      18: begin
        u = 32 * int'(c[12]) + 4 * int'(c[6:4]) + 64 * int'(c[3:2]);
        return (rd == 0) ? ILL : {1'b0, fi(u, 2, 2, rd, 3)};
      end
      19: begin
        u = 32 * int'(c[12]) + 8 * int'(c[6:5]) + 64 * int'(c[4:2]);
        return (rd == 0 || !x64) ? ILL : {1'b0, fi(u, 2, 3, rd, 3)};
      end
      20: if (!c[12]) begin
            if (r2 != 0) return {1'b0, fr(0, r2, 0, 0, rd, 'h33)};
            return (rd == 0) ? ILL : {1'b0, fi(0, rd, 0, 0, 'h67)};
          end else begin
            if (r2 != 0) return {1'b0, fr(0, r2, rd, 0, rd, 'h33)};
            if (rd == 0) return {1'b0, 32'h0010_0073};
            return {1'b0, fi(0, rd, 0, 1, 'h67)};
          end
      22: return {1'b0, fs(4 * int'(c[12:9]) + 64 * int'(c[8:7]), r2, 2, 2)};
      23: return x64 ? {1'b0, fs(8 * int'(c[12:10]) + 64 * int'(c[9:7]), r2, 2, 3)} : ILL;
      default: return ILL;
    endcase
  endfunction

  task automatic hand(string req, logic [15:0] c, logic x64, logic mc, logic eill,
                      logic [31:0] ew);
    in_insn = c; xlen64 = x64; misa_c = mc;
    #1;
    checks++;
    if (out_illegal !== eill || out_insn !== ew) begin
      failures++;
      $display("FAIL %s insn=%h x64=%0b: actual=%0b/%h expected=%0b/%h", req, c, x64,
               out_illegal, out_insn, eill, ew);
    end
  endtask

  initial begin
    in_valid = 1'b0; out_ready = 1'b0; in_insn = '0; xlen64 = 1'b0; misa_c = 1'b1;
    @(negedge clk);
    // R1 / R4 idle state: zero word
    #1; checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b0 || out_illegal !== 1'b1 || out_insn !== 0) begin
      failures++;
      $display("FAIL R4 idle: actual=%b%b%b/%h expected=001/00000000", out_valid, in_ready,
               out_illegal, out_insn);
    end
    // R1 handshake combinations
    for (int k = 0; k < 4; k++) begin
      in_valid = k[0]; out_ready = k[1]; in_insn = 16'h0505;
      #1; checks++;
      if (out_valid !== k[0] || in_ready !== k[1] || out_insn !== 32'h0015_0513) begin
        failures++;
        $display("FAIL R1 handshake: actual=%b%b/%h expected=%b%b/00150513", out_valid,
                 in_ready, out_insn, k[0], k[1]);
      end
    end
    in_valid = 1'b1; out_ready = 1'b1;
    hand("R2 disabled", 16'h0505, 1'b0, 1'b0, 1'b1, 32'h0);
    hand("R3 quadrant3", 16'h0513, 1'b0, 1'b1, 1'b1, 32'h0);
    hand("R4 zero", 16'h0000, 1'b1, 1'b1, 1'b1, 32'h0);
    hand("R5 lw a1,0(a0)", 16'h410C, 1'b0, 1'b1, 1'b0, 32'h0005_2583);
    hand("R6 mv", 16'h852E, 1'b0, 1'b1, 1'b0, 32'h00B0_0533);
    hand("R6 jr", 16'h8502, 1'b0, 1'b1, 1'b0, 32'h0005_0067);
    hand("R6 jr x0", 16'h8002, 1'b0, 1'b1, 1'b1, 32'h0);
    hand("R7 jalr", 16'h9502, 1'b0, 1'b1, 1'b0, 32'h0005_00E7);
    hand("R7 ebreak", 16'h9002, 1'b1, 1'b1, 1'b0, 32'h0010_0073);
    hand("R7 add", 16'h952E, 1'b0, 1'b1, 1'b0, 32'h00B5_0533);
    hand("R8 jal", 16'h2001, 1'b0, 1'b1, 1'b0, 32'h0000_00EF);
    hand("R8 addiw", 16'h2505, 1'b1, 1'b1, 1'b0, 32'h0015_051B);
    hand("R8 addiw x0", 16'h2001, 1'b1, 1'b1, 1'b1, 32'h0);
    hand("R9 beqz", 16'hC101, 1'b0, 1'b1, 1'b0, 32'h0005_0063);
    hand("R9 bnez", 16'hE101, 1'b0, 1'b1, 1'b0, 32'h0005_1063);
    hand("R10 ld rv32", 16'h6108, 1'b0, 1'b1, 1'b1, 32'h0);
    hand("R10 ld rv64", 16'h6108, 1'b1, 1'b1, 1'b0, 32'h0005_3503);
    hand("R10 subw rv32", 16'h9D0D, 1'b0, 1'b1, 1'b1, 32'h0);
    hand("R10 subw rv64", 16'h9D0D, 1'b1, 1'b1, 1'b0, 32'h40B5_053B);
    hand("R11 srai 32 rv32", 16'h9501, 1'b0, 1'b1, 1'b1, 32'h0);
    hand("R11 srai 32 rv64", 16'h9501, 1'b1, 1'b1, 1'b0, 32'h4205_5513);
    hand("R11 srai64", 16'h8501, 1'b1, 1'b1, 1'b1, 32'h0);
    hand("R12 lwsp x0", 16'h4002, 1'b0, 1'b1, 1'b1, 32'h0);
    hand("R12 fp slot", 16'h2000, 1'b1, 1'b1, 1'b1, 32'h0);
    // R13 / R2 exhaustive sweep at both widths, extension on and off
    for (int m = 0; m < 2; m++) begin
      for (int x = 0; x < 2; x++) begin
        for (int w = 0; w < 65536; w++) begin
          logic [32:0] e;
          in_insn = w[15:0]; xlen64 = x[0]; misa_c = m[0];
          in_valid = w[3]; out_ready = w[5];
          e = ref_exp(w[15:0], x[0], m[0]);
          #1; checks++;
          if ({out_illegal, out_insn} !== e || out_valid !== w[3] || in_ready !== w[5]) begin
            failures++;
            $display("FAIL %s sweep insn=%h x64=%0d: actual=%0b/%h expected=%0b/%h",
                     m ? "R13" : "R2", w[15:0], x, out_illegal, out_insn, e[32], e[31:0]);
          end
        end
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule